// File: doc/BRIEF.md
# Dual-Buffer Ethernet Receive Controller

This block is the receive side of a small Ethernet controller. Frame bytes arrive on a byte-wide stream with valid, ready and last. Each frame is packed into 32-bit words and written into one of two receive buffers. The buffers are taken in strict turn, starting with buffer 0 after reset. When a whole frame has been stored, the block raises a done flag in the status word of that buffer. The buffer then stays closed to new frames until software reads the frame and clears the flag.

Software sees both buffers through a simple word-wide register port. Reads return data one cycle after the request. The only writable words are the two status words. Bit 0 of a status word is the done flag and bit 3 is an interrupt enable. The interrupt output is high while any buffer has both its done flag and its enable set.

Stream rule: `s_ready` is low during reset and is held high at all other times. The block never applies back-pressure. A frame it cannot store is consumed in full and thrown away. A parameter can leave out the second buffer, and then every frame goes to buffer 0.

Top module: `dualbuf_rx`

## Requirements
- R1: `s_ready` is 0 while `rst_n` is low and 1 from the second clock edge after reset release onward, so every beat with `s_valid` high is consumed.
- R2: Byte k of a stored frame is placed at byte offset k of its buffer, in bits [8*(k mod 4)+7 : 8*(k mod 4)] of the word at offset 4*(k div 4). Lanes above the final byte in the last word of the frame read as 0.
- R3: The status word of buffer b sits at bus byte address BASE + b*BUF_BYTES + BUF_BYTES - 4, with the defaults 0x17FC and 0x1FFC. Its bit 0 (done) reads 0 while a frame is still being written to that buffer. The bit becomes 1 on the clock edge that accepts the last byte of a frame stored in full.
- R4: With two buffers, stored frames go alternately to buffer 0 (base 0x1000) and buffer 1 (base 0x1000 + BUF_BYTES). Buffer 0 is used first after reset.
- R5: A frame whose target buffer still has done = 1 is discarded entirely. That buffer keeps its contents, and the buffer order does not advance.
- R6: A bus write to a status word with bit 0 = 0 clears done. A write with bit 0 = 1 does not set it.
- R7: Every status write loads bit 3 (interrupt enable), and the block keeps it when it sets done. `irq` = OR over the buffers of (done AND enable).
- R8: A buffer holds at most BUF_BYTES - 4 frame bytes. For a longer frame the first BUF_BYTES - 4 bytes are stored, done stays 0 and the order does not advance. A frame of exactly BUF_BYTES - 4 bytes completes normally.
- R9: With DUAL = 0, every frame targets buffer 0. Addresses at or above BASE + BUF_BYTES read 0.
- R10: `bus_rdata` holds the addressed word in the cycle after `bus_rd`. Addresses outside the buffer window read 0, and bus writes to data words change nothing.
- R11: After reset both done flags and both enables are 0, and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| s_valid | input | 1 | Stream byte valid |
| s_ready | output | 1 | Stream ready (high except in reset) |
| s_data | input | 8 | Stream byte |
| s_last | input | 1 | Marks the final byte of a frame |
| bus_addr | input | AW (13) | Byte address of the register port |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| irq | output | 1 | Receive interrupt |

## Verification
The bench builds two copies of the block that share the same stream and bus stimulus. The first uses the default 2048-byte buffers with both buffers present. It covers alternation, drop on an occupied buffer, and the exact 2044-byte capacity boundary. The second has 64-byte buffers and a single buffer, so overflow happens after only 60 bytes. Random frame lengths therefore exercise truncation often, along with the single-buffer path and the read-as-zero region beyond that one buffer.

// File: rtl/dualbuf_rx_pkg.sv
`timescale 1ns/1ps
package dualbuf_rx_pkg;
  localparam int unsigned DONE_BIT = 0;
  localparam int unsigned IE_BIT   = 3;

  typedef struct packed {
    logic ie;
    logic done;
  } rx_stat_t;

  function automatic logic [31:0] stat_word(rx_stat_t s);
    logic [31:0] w;
    w           = '0;
    w[DONE_BIT] = s.done;
    w[IE_BIT]   = s.ie;
    return w;
  endfunction
endpackage

// File: rtl/dualbuf_rx_framer.sv
`timescale 1ns/1ps
module dualbuf_rx_framer #(
  parameter int unsigned BW   = 11,
  parameter bit          DUAL = 1'b1,
  parameter int unsigned RW   = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [7:0]    s_data,
  input  logic          s_last,
  input  logic [1:0]    bank_done,
  output logic          wr_en,
  output logic          wr_bank,
  output logic [RW-1:0] wr_idx,
  output logic [31:0]   wr_data,
  output logic [1:0]    set_done
);
  localparam int unsigned CAP        = (1 << BW) - 4;
  localparam int unsigned DATA_WORDS = (1 << RW) - 1;

  logic          ready_q, in_frame, dropping, cur_bank, sel;
  logic [BW-1:0] byte_cnt;
  logic [23:0]   pack;
  logic          beat, tgt, drop_now, room, keep, complete;
  logic [1:0]    lane;
  logic [31:0]   word_next;

  assign s_ready  = ready_q;
  assign beat     = s_valid & ready_q;
  assign tgt      = in_frame ? cur_bank : sel;
  assign drop_now = in_frame ? dropping : bank_done[sel];
  assign room     = byte_cnt < BW'(CAP);
  assign lane     = byte_cnt[1:0];
  assign keep     = beat & ~drop_now;
  assign complete = keep & s_last & room;

  always_comb begin
    word_next = (lane == 2'd0) ? 32'd0 : {8'd0, pack};
    word_next[{lane, 3'b000} +: 8] = s_data;
  end

  assign wr_en    = keep & room & ((lane == 2'd3) | s_last);
  assign wr_bank  = tgt;
  assign wr_idx   = byte_cnt[BW-1:2];
  assign wr_data  = word_next;
  assign set_done = complete ? (tgt ? 2'b10 : 2'b01) : 2'b00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ready_q  <= 1'b0;
      in_frame <= 1'b0;
      dropping <= 1'b0;
      cur_bank <= 1'b0;
      sel      <= 1'b0;
      byte_cnt <= '0;
      pack     <= '0;
    end else begin
      ready_q <= 1'b1;
      if (beat) begin
        if (s_last) begin
          in_frame <= 1'b0;
          dropping <= 1'b0;
          byte_cnt <= '0;
          if (complete && DUAL) sel <= ~sel;
        end else begin
          in_frame <= 1'b1;
          cur_bank <= tgt;
          dropping <= drop_now;
          if (keep && room) byte_cnt <= byte_cnt + 1'b1;
        end
        if (keep) pack <= word_next[23:0];
      end
    end
  end

  // R8: writes never reach the status word slot
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_idx < RW'(DATA_WORDS)));
  // R5: a frame completes only into a buffer whose done flag is clear
  assert_free_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_done) |-> ((set_done & bank_done) == 2'b00));
  // R4: the buffer order moves only after a frame completed
  assert_order_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel != $past(sel)) |-> $past(|set_done));
  // R1: once ready, stays ready
  assert_ready_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ready_q) |-> ready_q);

  if (!DUAL) begin : g_single_chk
    // R9: single-buffer build only ever writes buffer 0
    assert_single_bank_R9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> !wr_bank);
  end
endmodule

// File: rtl/dualbuf_rx_bank.sv
`timescale 1ns/1ps
module dualbuf_rx_bank import dualbuf_rx_pkg::*; #(
  parameter int unsigned RW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [RW-1:0] wr_idx,
  input  logic [31:0]   wr_data,
  input  logic          set_done,
  input  logic          st_wr,
  input  logic          st_done_bit,
  input  logic          st_ie_bit,
  input  logic          rd_en,
  input  logic [RW-1:0] rd_idx,
  output logic [31:0]   rd_data,
  output rx_stat_t      stat
);
  localparam int unsigned DATA_WORDS = (1 << RW) - 1;

  logic [31:0] mem [DATA_WORDS];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat <= '0;
    end else begin
      if (set_done)                  stat.done <= 1'b1;
      else if (st_wr && !st_done_bit) stat.done <= 1'b0;
      if (st_wr) stat.ie <= st_ie_bit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      rd_data <= '0;
    else if (rd_en)
      rd_data <= (rd_idx == RW'(DATA_WORDS)) ? stat_word(stat) : mem[rd_idx];
  end

  // R3: done rises only through a completed frame
  assert_done_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat.done) |-> $past(set_done));
  // R6: done falls only through a status write carrying bit 0 = 0
  assert_done_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stat.done) |-> $past(st_wr && !st_done_bit));
  // R7: the enable changes only on a status write
  assert_ie_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat.ie != $past(stat.ie)) |-> $past(st_wr));
endmodule

// File: rtl/dualbuf_rx.sv
`timescale 1ns/1ps
module dualbuf_rx import dualbuf_rx_pkg::*; #(
  parameter int unsigned          BUF_BYTES = 2048,
  parameter bit                   DUAL      = 1'b1,
  parameter int unsigned          AW        = 13,
  parameter logic [AW-1:0]        BASE_ADDR = 'h1000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [7:0]    s_data,
  input  logic          s_last,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          irq
);
  localparam int unsigned BW       = $clog2(BUF_BYTES);
  localparam int unsigned RW       = BW - 2;
  localparam int unsigned NBANKS   = DUAL ? 2 : 1;
  localparam int unsigned STAT_IDX = BUF_BYTES / 4 - 1;
  localparam logic [AW:0] SPAN     = (AW+1)'(NBANKS * BUF_BYTES);

  logic [AW-1:0] off;
  logic          in_rng, bank_sel, is_stat;
  logic [RW-1:0] word_idx;
  logic          unused_wdata_bits;

  assign off      = bus_addr - BASE_ADDR;
  assign in_rng   = (bus_addr >= BASE_ADDR) && ({1'b0, off} < SPAN);
  assign bank_sel = off[BW];
  assign word_idx = off[BW-1:2];
  assign is_stat  = (word_idx == RW'(STAT_IDX));
  assign unused_wdata_bits = ^{bus_wdata[31:4], bus_wdata[2:1]};

  logic          fr_wr_en, fr_wr_bank;
  logic [RW-1:0] fr_wr_idx;
  logic [31:0]   fr_wr_data;
  logic [1:0]    fr_set_done, bank_done;
  logic [31:0]   bk_rdata [2];
  rx_stat_t      bk_stat  [2];

  dualbuf_rx_framer #(.BW(BW), .DUAL(DUAL), .RW(RW)) u_framer (
    .clk       (clk),
    .rst_n     (rst_n),
    .s_valid   (s_valid),
    .s_ready   (s_ready),
    .s_data    (s_data),
    .s_last    (s_last),
    .bank_done (bank_done),
    .wr_en     (fr_wr_en),
    .wr_bank   (fr_wr_bank),
    .wr_idx    (fr_wr_idx),
    .wr_data   (fr_wr_data),
    .set_done  (fr_set_done)
  );

  for (genvar b = 0; b < 2; b++) begin : g_bank
    if (b < NBANKS) begin : g_on
      dualbuf_rx_bank #(.RW(RW)) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (fr_wr_en && (fr_wr_bank == 1'(b))),
        .wr_idx      (fr_wr_idx),
        .wr_data     (fr_wr_data),
        .set_done    (fr_set_done[b]),
        .st_wr       (bus_wr && in_rng && (bank_sel == 1'(b)) && is_stat),
        .st_done_bit (bus_wdata[DONE_BIT]),
        .st_ie_bit   (bus_wdata[IE_BIT]),
        .rd_en       (bus_rd && in_rng && (bank_sel == 1'(b))),
        .rd_idx      (word_idx),
        .rd_data     (bk_rdata[b]),
        .stat        (bk_stat[b])
      );
    end else begin : g_off
      assign bk_rdata[b] = '0;
      assign bk_stat[b]  = '0;
    end
    assign bank_done[b] = bk_stat[b].done;
  end

  logic rd_hit_q, rd_bank_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_hit_q  <= 1'b0;
      rd_bank_q <= 1'b0;
    end else begin
      rd_hit_q  <= bus_rd && in_rng;
      rd_bank_q <= bank_sel;
    end
  end

  assign bus_rdata = rd_hit_q ? bk_rdata[rd_bank_q] : 32'd0;
  assign irq = (bk_stat[0].done & bk_stat[0].ie) | (bk_stat[1].done & bk_stat[1].ie);

  // R10: a read outside the buffer window returns zero
  assert_oob_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(bus_rd) && !$past(in_rng)) |-> (bus_rdata == 32'd0));
endmodule

// File: tb/dualbuf_rx_tb.sv
`timescale 1ns/1ps
module dualbuf_rx_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        s_valid = 1'b0, s_last = 1'b0;
  logic [7:0]  s_data = '0;
  logic [12:0] bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        rdy0, rdy1, irq0, irq1;
  logic [31:0] rd0, rd1;

  always #2.5 clk = ~clk;

  dualbuf_rx #(.BUF_BYTES(2048), .DUAL(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(rdy0), .s_data(s_data),
    .s_last(s_last), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(rd0), .irq(irq0));

  dualbuf_rx #(.BUF_BYTES(64), .DUAL(1'b0)) u_dut_single (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(rdy1), .s_data(s_data),
    .s_last(s_last), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(rd1), .irq(irq1));

  int n_cmp = 0, n_err = 0, cyc = 0;
  byte unsigned m_mem [2][2][2048];
  bit           m_vld [2][2][2048];
  bit           m_done[2][2], m_ie[2][2], m_sel[2];
  int           bb[2] = '{2048, 64};
  int           nb[2] = '{2, 1};
  byte unsigned fb[4096];

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000) begin
      n_cmp++; n_err++;
      $display("FAIL watchdog: actual %0d cycles, expected completion earlier", cyc);
      summary();
      $finish;
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  function automatic logic [32:0] exp_rd(int d, int a);
    int off, b, w;
    logic [31:0] v;
    bit k;
    if (a < 'h1000 || a - 'h1000 >= nb[d] * bb[d]) return {1'b1, 32'd0};
    off = a - 'h1000;
    b = off / bb[d];
    w = (off % bb[d]) / 4;
    if (w == bb[d] / 4 - 1) return {1'b1, 28'd0, m_ie[d][b], 2'b00, m_done[d][b]};
    k = 1'b1; v = '0;
    for (int i = 0; i < 4; i++) begin
      if (!m_vld[d][b][4*w+i]) k = 1'b0;
      v[8*i +: 8] = m_mem[d][b][4*w+i];
    end
    return {k, v};
  endfunction

  function automatic void apply_frame(int d, int len);
    int t, cap;
    t = m_sel[d];
    cap = bb[d] - 4;
    if (m_done[d][t]) return;
    for (int i = 0; i < len && i < cap; i++) begin
      m_mem[d][t][i] = fb[i];
      m_vld[d][t][i] = 1'b1;
    end
    if (len <= cap) begin
      for (int i = len; i % 4 != 0; i++) begin
        m_mem[d][t][i] = 8'd0;
        m_vld[d][t][i] = 1'b1;
      end
      m_done[d][t] = 1'b1;
      if (nb[d] == 2) m_sel[d] = ~m_sel[d];
    end
  endfunction

  // all tasks start and end at a falling edge
  task automatic bus_read(int a);
    bus_addr = 13'(a); bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic rd_cmp(string tag, int a);
    logic [32:0] e;
    bus_read(a);
    for (int d = 0; d < 2; d++) begin
      e = exp_rd(d, a);
      if (e[32]) check(tag, (d == 0) ? rd0 : rd1, e[31:0]);
    end
  endtask

  task automatic bus_write(int a, logic [31:0] v);
    int off;
    bus_addr = 13'(a); bus_wdata = v; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    for (int d = 0; d < 2; d++) begin
      off = a - 'h1000;
      if (a >= 'h1000 && off < nb[d] * bb[d] && (off % bb[d]) / 4 == bb[d] / 4 - 1) begin
        if (!v[0]) m_done[d][off / bb[d]] = 1'b0;
        m_ie[d][off / bb[d]] = v[3];
      end
    end
  endtask

  task automatic push(byte unsigned b, bit last);
    s_data = b; s_last = last; s_valid = 1'b1;
    @(negedge clk);
    s_valid = 1'b0; s_last = 1'b0;
  endtask

  task automatic send_frame(int len, bit gaps, bit mid);
    for (int i = 0; i < len; i++) fb[i] = 8'($urandom);
    for (int i = 0; i < len; i++) begin
      if (mid && i == len - 1) rd_cmp("R3 done hidden mid-frame", 'h1000 + m_sel[0] * 2048 + 2044);
      push(fb[i], i == len - 1);
      if (gaps && $urandom_range(0, 3) == 0) @(negedge clk);
    end
    for (int d = 0; d < 2; d++) apply_frame(d, len);
  endtask

  task automatic check_irq();
    check("R7 irq dual", {31'd0, irq0},
          {31'd0, (m_done[0][0] & m_ie[0][0]) | (m_done[0][1] & m_ie[0][1])});
    check("R7 irq single", {31'd0, irq1}, {31'd0, m_done[1][0] & m_ie[1][0]});
  endtask

  task automatic verify_all();
    for (int b = 0; b < 2; b++) begin
      for (int w = 0; w < 24; w++) rd_cmp("R2 data word", 'h1000 + b * 2048 + 4 * w);
      rd_cmp("R3 status word", 'h1000 + b * 2048 + 2044);
    end
    for (int w = 0; w < 17; w++) rd_cmp("R9 single window", 'h1000 + 4 * w);
    check_irq();
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    check("R1 ready low in reset", {31'd0, rdy0}, 32'd0);
    check("R11 irq low in reset", {31'd0, irq0 | irq1}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 ready dual", {31'd0, rdy0}, 32'd1);
    check("R1 ready single", {31'd0, rdy1}, 32'd1);
    rd_cmp("R11 status0 reset", 'h17FC);
    rd_cmp("R11 status1 reset", 'h1FFC);
    rd_cmp("R11 single status reset", 'h103C);

    // first frame, held before its last byte
    send_frame(10, 1'b0, 1'b1);
    rd_cmp("R3 done after last", 'h17FC);
    rd_cmp("R2 word0", 'h1000);
    rd_cmp("R2 padded word", 'h1008);
    // second frame goes to buffer 1; single build drops it
    send_frame(7, 1'b1, 1'b0);
    rd_cmp("R4 buffer1 done", 'h1FFC);
    rd_cmp("R4 buffer1 word1", 'h1804);
    rd_cmp("R5 single keeps first frame", 'h1004);
    // both buffers busy: drop
    send_frame(5, 1'b0, 1'b0);
    rd_cmp("R5 buffer0 untouched", 'h1000);
    bus_write('h17FC, 32'h1);
    rd_cmp("R6 write one keeps done", 'h17FC);
    bus_write('h17FC, 32'h0);
    rd_cmp("R6 cleared", 'h17FC);
    send_frame(9, 1'b1, 1'b0);
    rd_cmp("R5 order not advanced by drop", 'h17FC);
    rd_cmp("R5 new data buffer0", 'h1004);
    verify_all();

    // interrupt enable
    bus_write('h1FFC, 32'h9);
    rd_cmp("R7 enable with done kept", 'h1FFC);
    check_irq();
    check("R7 irq raised", {31'd0, irq0}, 32'd1);
    bus_write('h1FFC, 32'h8);
    rd_cmp("R7 enable kept on clear", 'h1FFC);
    check("R7 irq dropped", {31'd0, irq0}, 32'd0);
    send_frame(12, 1'b0, 1'b0);
    rd_cmp("R7 enable kept across done set", 'h1FFC);
    check("R7 irq on new frame", {31'd0, irq0}, 32'd1);

    // read path
    rd_cmp("R10 below window", 'h0000);
    rd_cmp("R10 just below window", 'h0FFC);
    bus_write('h1000, 32'hDEADBEEF);
    bus_write('h1800, 32'hDEADBEEF);
    rd_cmp("R10 data write ignored b0", 'h1000);
    rd_cmp("R10 data write ignored b1", 'h1800);
    rd_cmp("R9 single second bank absent", 'h1040);

    // overflow and exact capacity
    bus_write('h17FC, 32'h0);
    bus_write('h1FFC, 32'h0);
    bus_write('h103C, 32'h0);
    send_frame(2045, 1'b0, 1'b0);
    rd_cmp("R8 overflow no done", 'h17FC);
    rd_cmp("R8 overflow last word stored", 'h17F8);
    rd_cmp("R8 single overflow no done", 'h103C);
    rd_cmp("R8 single last word", 'h1038);
    send_frame(2044, 1'b0, 1'b0);
    rd_cmp("R8 exact capacity done", 'h17FC);
    rd_cmp("R8 exact capacity last word", 'h17F8);
    rd_cmp("R8 order after overflow", 'h1FFC);
    send_frame(60, 1'b1, 1'b0);
    rd_cmp("R8 single exact capacity", 'h103C);
    rd_cmp("R4 buffer1 after capacity frame", 'h1FFC);
    verify_all();

    // constrained random traffic
    for (int f = 0; f < 150; f++) begin
      send_frame($urandom_range(1, 80), 1'b1, 1'b0);
      for (int k = 0; k < 2; k++) begin
        if ($urandom_range(0, 2) != 0) begin
          case ($urandom_range(0, 2))
            0: bus_write('h17FC, $urandom & 32'h9);
            1: bus_write('h1FFC, $urandom & 32'h9);
            default: bus_write('h103C, $urandom & 32'h9);
          endcase
        end
      end
      verify_all();
    end

    summary();
    $finish;
  end
endmodule